// File: doc/BRIEF.md
# Per-CPU Private Interrupt Tracker

This block keeps the private interrupt state of a small cluster of CPUs. Each CPU owns 32 interrupt IDs: IDs 0 to 15 are software-generated and IDs 16 to 31 are private peripheral lines. For every CPU the block holds its own pending vector, its own active vector and its own table of 8-bit priorities. No state is shared between CPUs.

A source raises an ID for one CPU through that CPU's raise strobe. Every cycle, the block searches each CPU's pending IDs for the most urgent one and presents the result as a registered ID and priority. A CPU acknowledges the presented ID, which moves the ID from pending to active. The CPU signals end-of-interrupt with an explicit ID, which retires the active entry. The running priority of each CPU is the most urgent priority among its active IDs. It is recomputed only while that CPU's interface is enabled. An end-of-interrupt for an ID that is not active raises an error pulse.

Priorities are written one entry at a time. A combinational read port returns any stored entry. CPU indices on all inputs must be below `NUM_CPU`.

Top module: `private_irq_tracker`

## Requirements
- R1: After reset every pending and active bit is 0, every stored priority reads 0, `hp_valid_o` is 0, every `hp_prio_o` and `run_prio_o` field is 0xFF, and `err_o` is 0.
- R2: A raise strobe on CPU c with ID n sets pending bit n of CPU c only. The state of every other CPU is left unchanged.
- R3: A smaller priority value is more urgent. The presented ID is the pending ID with the smallest priority value. On equal values the lower ID wins. A pending ID whose priority is 0xFF is never presented. With nothing presentable, `hp_valid_o` is 0, the ID field is 0 and the priority field is 0xFF.
- R4: The presented ID and priority are registered. They reflect the pending state and priority table one cycle after a change.
- R5: An acknowledge for CPU c while that CPU's presented entry is valid sets the active bit of the presented ID and clears its pending bit. With no valid presented entry, an acknowledge changes nothing.
- R6: When a raise and an acknowledge hit the same pending bit in the same cycle, the bit stays pending and also becomes active.
- R7: End-of-interrupt for CPU c, ID n clears active bit n of CPU c. If that bit was already 0, `err_o` is 1 for exactly the following cycle and no state changes.
- R8: An enabled CPU's running priority equals the smallest priority value over its active IDs, or 0xFF when none are active. It is registered one cycle behind the active state.
- R9: While `cpu_en_i[c]` is 0, the running priority of CPU c holds its last value.
- R10: A priority write changes only the addressed CPU's entry for the addressed ID. The read port returns the stored value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_en_i | input | NUM_CPU | Per-CPU interface enable; gates the running-priority update |
| raise_vld_i | input | NUM_CPU | Per-CPU raise strobe |
| raise_id_i | input | NUM_CPU*5 | Per-CPU raised ID; CPU c uses bits [c*5 +: 5] |
| ack_i | input | 1 | Acknowledge request |
| ack_cpu_i | input | CPU_W | CPU issuing the acknowledge |
| eoi_i | input | 1 | End-of-interrupt request |
| eoi_cpu_i | input | CPU_W | CPU issuing the end-of-interrupt |
| eoi_id_i | input | 5 | ID being retired |
| prio_we_i | input | 1 | Priority write strobe |
| prio_wr_cpu_i | input | CPU_W | CPU whose priority table is written |
| prio_wr_id_i | input | 5 | ID whose priority is written |
| prio_wdata_i | input | 8 | Priority value to write |
| prio_rd_cpu_i | input | CPU_W | CPU for the priority read |
| prio_rd_id_i | input | 5 | ID for the priority read |
| prio_rd_data_o | output | 8 | Stored priority at the read address |
| hp_valid_o | output | NUM_CPU | Per-CPU flag that a presentable pending ID exists |
| hp_id_o | output | NUM_CPU*5 | Per-CPU presented ID |
| hp_prio_o | output | NUM_CPU*8 | Per-CPU presented priority, 0xFF when none |
| run_prio_o | output | NUM_CPU*8 | Per-CPU running priority |
| err_o | output | 1 | One-cycle pulse after an end-of-interrupt for an inactive ID |

## Verification
The priority table is filled with an arithmetic pattern in which IDs that are 8 apart share a value. Raising several such IDs in turn separates a strict minimum from a lowest-ID tie-break, because a scan that resolves ties the other way presents the higher ID. Every ID on every CPU is also raised, acknowledged and retired on its own while the other CPU is observed. This exposes leakage between CPUs and wrong bit positions. Further patterns cover several active IDs at once, which tests the running minimum, as well as an 0xFF priority, an acknowledge with nothing presented, a raise colliding with an acknowledge, a retire of an inactive ID, and a disabled CPU. Each of these separates one ordering or gating rule from its plausible alternatives.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int NUM_SGI = 16;
  localparam int NUM_PPI = 16;
  localparam int NUM_ID  = NUM_SGI + NUM_PPI;
  localparam int ID_W    = $clog2(NUM_ID);
  localparam int PRIO_W  = 8;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [ID_W-1:0]   id_t;
endpackage

// File: rtl/pit_prio_store.sv
module pit_prio_store
  import pit_pkg::*;
#(
  parameter int NUM_CPU = 2,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  we_i,
  input  logic [CPU_W-1:0]                      wr_cpu_i,
  input  id_t                                   wr_id_i,
  input  prio_t                                 wdata_i,
  input  logic [CPU_W-1:0]                      rd_cpu_i,
  input  id_t                                   rd_id_i,
  output prio_t                                 rdata_o,
  output logic [NUM_CPU-1:0][NUM_ID-1:0][PRIO_W-1:0] tab_o
);
  logic [NUM_CPU-1:0][NUM_ID-1:0][PRIO_W-1:0] tab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tab_q <= '0;
    else if (we_i) tab_q[wr_cpu_i][wr_id_i] <= wdata_i;
  end

  assign rdata_o = tab_q[rd_cpu_i][rd_id_i];
  assign tab_o   = tab_q;
endmodule

// File: rtl/pit_cpu_state.sv
module pit_cpu_state
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raise_i,
  input  id_t               raise_id_i,
  input  logic              ack_i,
  input  id_t               ack_id_i,
  input  logic              eoi_i,
  input  id_t               eoi_id_i,
  output logic [NUM_ID-1:0] pend_o,
  output logic [NUM_ID-1:0] act_o,
  output logic              eoi_bad_o
);
  logic [NUM_ID-1:0] pend_q, act_q;
  logic [NUM_ID-1:0] raise_bit, ack_bit, eoi_bit;

  always_comb begin
    raise_bit = raise_i ? (NUM_ID'(1) << raise_id_i) : '0;
    ack_bit   = ack_i   ? (NUM_ID'(1) << ack_id_i)   : '0;
    eoi_bit   = eoi_i   ? (NUM_ID'(1) << eoi_id_i)   : '0;
  end

  assign eoi_bad_o = eoi_i && !act_q[eoi_id_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      // raise is applied after the acknowledge clear, so it wins a collision
      pend_q <= (pend_q & ~ack_bit) | raise_bit;
      act_q  <= (act_q & ~eoi_bit) | ack_bit;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/pit_min_sel.sv
module pit_min_sel
  import pit_pkg::*;
(
  input  logic [NUM_ID-1:0]             mask_i,
  input  logic [NUM_ID-1:0][PRIO_W-1:0] prio_i,
  output id_t                           idx_o,
  output prio_t                         best_o
);
  // ascending scan with strict compare: lowest ID wins ties, 0xFF never wins
  always_comb begin
    idx_o  = '0;
    best_o = PRIO_NONE;
    for (int i = 0; i < NUM_ID; i++) begin
      if (mask_i[i] && (prio_i[i] < best_o)) begin
        best_o = prio_i[i];
        idx_o  = id_t'(i);
      end
    end
  end
endmodule

// File: rtl/private_irq_tracker.sv
module private_irq_tracker
  import pit_pkg::*;
#(
  parameter int NUM_CPU = 2,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CPU-1:0]       cpu_en_i,
  input  logic [NUM_CPU-1:0]       raise_vld_i,
  input  logic [NUM_CPU*ID_W-1:0]  raise_id_i,
  input  logic                     ack_i,
  input  logic [CPU_W-1:0]         ack_cpu_i,
  input  logic                     eoi_i,
  input  logic [CPU_W-1:0]         eoi_cpu_i,
  input  logic [ID_W-1:0]          eoi_id_i,
  input  logic                     prio_we_i,
  input  logic [CPU_W-1:0]         prio_wr_cpu_i,
  input  logic [ID_W-1:0]          prio_wr_id_i,
  input  logic [PRIO_W-1:0]        prio_wdata_i,
  input  logic [CPU_W-1:0]         prio_rd_cpu_i,
  input  logic [ID_W-1:0]          prio_rd_id_i,
  output logic [PRIO_W-1:0]        prio_rd_data_o,
  output logic [NUM_CPU-1:0]       hp_valid_o,
  output logic [NUM_CPU*ID_W-1:0]  hp_id_o,
  output logic [NUM_CPU*PRIO_W-1:0] hp_prio_o,
  output logic [NUM_CPU*PRIO_W-1:0] run_prio_o,
  output logic                     err_o
);
  logic [NUM_CPU-1:0][NUM_ID-1:0][PRIO_W-1:0] prio_tab;
  logic [NUM_CPU-1:0][NUM_ID-1:0]             pend_q, act_q;
  logic [NUM_CPU-1:0]                         eoi_bad;
  logic                                       err_q;

  pit_prio_store #(.NUM_CPU(NUM_CPU)) u_prio (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (prio_we_i),
    .wr_cpu_i (prio_wr_cpu_i),
    .wr_id_i  (prio_wr_id_i),
    .wdata_i  (prio_wdata_i),
    .rd_cpu_i (prio_rd_cpu_i),
    .rd_id_i  (prio_rd_id_i),
    .rdata_o  (prio_rd_data_o),
    .tab_o    (prio_tab)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic  hp_valid_q;
    id_t   hp_id_q, hp_idx, run_idx_unused;
    prio_t hp_prio_q, hp_best, run_best, run_q;
    logic  ack_hit, eoi_hit;

    assign ack_hit = ack_i && (ack_cpu_i == CPU_W'(c)) && hp_valid_q;
    assign eoi_hit = eoi_i && (eoi_cpu_i == CPU_W'(c));

    pit_cpu_state u_state (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .raise_i    (raise_vld_i[c]),
      .raise_id_i (raise_id_i[c*ID_W +: ID_W]),
      .ack_i      (ack_hit),
      .ack_id_i   (hp_id_q),
      .eoi_i      (eoi_hit),
      .eoi_id_i   (eoi_id_i),
      .pend_o     (pend_q[c]),
      .act_o      (act_q[c]),
      .eoi_bad_o  (eoi_bad[c])
    );

    pit_min_sel u_hp_sel (
      .mask_i (pend_q[c]),
      .prio_i (prio_tab[c]),
      .idx_o  (hp_idx),
      .best_o (hp_best)
    );

    pit_min_sel u_run_sel (
      .mask_i (act_q[c]),
      .prio_i (prio_tab[c]),
      .idx_o  (run_idx_unused),
      .best_o (run_best)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hp_valid_q <= 1'b0;
        hp_id_q    <= '0;
        hp_prio_q  <= PRIO_NONE;
        run_q      <= PRIO_NONE;
      end else begin
        hp_valid_q <= (hp_best != PRIO_NONE);
        hp_id_q    <= hp_idx;
        hp_prio_q  <= hp_best;
        if (cpu_en_i[c]) run_q <= run_best;
      end
    end

    assign hp_valid_o[c]                 = hp_valid_q;
    assign hp_id_o[c*ID_W +: ID_W]       = hp_id_q;
    assign hp_prio_o[c*PRIO_W +: PRIO_W] = hp_prio_q;
    assign run_prio_o[c*PRIO_W +: PRIO_W] = run_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= |eoi_bad;
  end

  assign err_o = err_q;
endmodule

// File: rtl/private_irq_tracker_chk.sv
module private_irq_tracker_chk
  import pit_pkg::*;
#(
  parameter int NUM_CPU = 2,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic [NUM_CPU-1:0]                 cpu_en_i,
  input logic                               ack_i,
  input logic [CPU_W-1:0]                   ack_cpu_i,
  input logic                               eoi_i,
  input logic [CPU_W-1:0]                   eoi_cpu_i,
  input logic [ID_W-1:0]                    eoi_id_i,
  input logic [NUM_CPU-1:0]                 hp_valid_o,
  input logic [NUM_CPU*ID_W-1:0]            hp_id_o,
  input logic [NUM_CPU*PRIO_W-1:0]          run_prio_o,
  input logic                               err_o,
  input logic [NUM_CPU-1:0][NUM_ID-1:0]     pend_q,
  input logic [NUM_CPU-1:0][NUM_ID-1:0]     act_q
);
  logic [NUM_CPU-1:0][NUM_ID-1:0] pend_d1, act_d1;
  logic [NUM_CPU-1:0]             en_d1, ack_hit_d1;
  logic [NUM_CPU-1:0][ID_W-1:0]   ack_id_d1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_d1    <= '0;
      act_d1     <= '0;
      en_d1      <= '0;
      ack_hit_d1 <= '0;
      ack_id_d1  <= '0;
    end else begin
      pend_d1 <= pend_q;
      act_d1  <= act_q;
      en_d1   <= cpu_en_i;
      for (int c = 0; c < NUM_CPU; c++) begin
        ack_hit_d1[c] <= ack_i && (ack_cpu_i == CPU_W'(c)) && hp_valid_o[c];
        ack_id_d1[c]  <= hp_id_o[c*ID_W +: ID_W];
      end
    end
  end

  // R7
  a_r7_bad_eoi_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !act_q[eoi_cpu_i][eoi_id_i]) |=> err_o);
  // R7
  a_r7_err_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(eoi_i));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    // R3
    a_r3_presented_was_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hp_valid_o[c] |-> pend_d1[c][hp_id_o[c*ID_W +: ID_W]]);
    // R5
    a_r5_ack_sets_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_hit_d1[c] |-> act_q[c][ack_id_d1[c]]);
    // R8
    a_r8_idle_run_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_d1[c] && (act_d1[c] == '0)) |-> (run_prio_o[c*PRIO_W +: PRIO_W] == PRIO_NONE));
    // R9
    a_r9_disabled_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cpu_en_i[c] |=> $stable(run_prio_o[c*PRIO_W +: PRIO_W]));
  end
endmodule

bind private_irq_tracker private_irq_tracker_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_en_i   (cpu_en_i),
  .ack_i      (ack_i),
  .ack_cpu_i  (ack_cpu_i),
  .eoi_i      (eoi_i),
  .eoi_cpu_i  (eoi_cpu_i),
  .eoi_id_i   (eoi_id_i),
  .hp_valid_o (hp_valid_o),
  .hp_id_o    (hp_id_o),
  .run_prio_o (run_prio_o),
  .err_o      (err_o),
  .pend_q     (pend_q),
  .act_q      (act_q)
);

// File: tb/private_irq_tracker_bench.sv
`timescale 1ns/1ps
module private_irq_tracker_bench;
  localparam int NC = 2;
  localparam int NI = 32;
  localparam int IW = 5;
  localparam int PW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NC-1:0]    cpu_en_i = '1;
  logic [NC-1:0]    raise_vld_i = '0;
  logic [NC*IW-1:0] raise_id_i = '0;
  logic             ack_i = 1'b0;
  logic             ack_cpu_i = 1'b0;
  logic             eoi_i = 1'b0;
  logic             eoi_cpu_i = 1'b0;
  logic [IW-1:0]    eoi_id_i = '0;
  logic             prio_we_i = 1'b0;
  logic             prio_wr_cpu_i = 1'b0;
  logic [IW-1:0]    prio_wr_id_i = '0;
  logic [PW-1:0]    prio_wdata_i = '0;
  logic             prio_rd_cpu_i = 1'b0;
  logic [IW-1:0]    prio_rd_id_i = '0;
  logic [PW-1:0]    prio_rd_data_o;
  logic [NC-1:0]    hp_valid_o;
  logic [NC*IW-1:0] hp_id_o;
  logic [NC*PW-1:0] hp_prio_o;
  logic [NC*PW-1:0] run_prio_o;
  logic             err_o;

  always #4 clk_i = ~clk_i;

  private_irq_tracker #(.NUM_CPU(NC)) u_private_irq_tracker (
    .clk_i, .rst_ni, .cpu_en_i, .raise_vld_i, .raise_id_i,
    .ack_i, .ack_cpu_i, .eoi_i, .eoi_cpu_i, .eoi_id_i,
    .prio_we_i, .prio_wr_cpu_i, .prio_wr_id_i, .prio_wdata_i,
    .prio_rd_cpu_i, .prio_rd_id_i, .prio_rd_data_o,
    .hp_valid_o, .hp_id_o, .hp_prio_o, .run_prio_o, .err_o
  );

  int vectors = 0;
  int miscompares = 0;
  int pend_m [NC][NI];
  int act_m  [NC][NI];
  int prio_m [NC][NI];
  int run_m  [NC];

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check(string req, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int pattern(int c, int id);
    return ((id % 8) * 24) + c * 5 + 10;
  endfunction

  task automatic model_hp(int c, output int v, output int id, output int p);
    p = 255; id = 0; v = 0;
    for (int i = 0; i < NI; i++)
      if (pend_m[c][i] != 0 && prio_m[c][i] < p) begin
        p = prio_m[c][i]; id = i; v = 1;
      end
  endtask

  function automatic int model_run(int c);
    int m = 255;
    for (int i = 0; i < NI; i++)
      if (act_m[c][i] != 0 && prio_m[c][i] < m) m = prio_m[c][i];
    return m;
  endfunction

  task automatic check_state(string req);
    int v, id, p;
    for (int c = 0; c < NC; c++) begin
      model_hp(c, v, id, p);
      check(req, $sformatf("cpu%0d hp_valid", c), int'(hp_valid_o[c]), v);
      if (v != 0) check(req, $sformatf("cpu%0d hp_id", c), int'(hp_id_o[c*IW +: IW]), id);
      check(req, $sformatf("cpu%0d hp_prio", c), int'(hp_prio_o[c*PW +: PW]), p);
      if (cpu_en_i[c]) run_m[c] = model_run(c);
      check(req, $sformatf("cpu%0d run_prio", c), int'(run_prio_o[c*PW +: PW]), run_m[c]);
    end
  endtask

  task automatic do_prio(int c, int id, int val);
    prio_we_i = 1'b1; prio_wr_cpu_i = c[0]; prio_wr_id_i = id[IW-1:0]; prio_wdata_i = val[PW-1:0];
    tick();
    prio_we_i = 1'b0;
    prio_m[c][id] = val;
  endtask

  task automatic do_raise(int c, int id, string req);
    raise_vld_i[c] = 1'b1; raise_id_i[c*IW +: IW] = id[IW-1:0];
    tick();
    raise_vld_i = '0;
    pend_m[c][id] = 1;
    tick();
    check_state(req);
  endtask

  task automatic do_ack(int c, string req);
    int v, id, p;
    model_hp(c, v, id, p);
    ack_i = 1'b1; ack_cpu_i = c[0];
    tick();
    ack_i = 1'b0;
    if (v != 0) begin act_m[c][id] = 1; pend_m[c][id] = 0; end
    tick();
    check_state(req);
  endtask

  task automatic do_eoi(int c, int id, string req);
    int bad;
    bad = (act_m[c][id] == 0) ? 1 : 0;
    eoi_i = 1'b1; eoi_cpu_i = c[0]; eoi_id_i = id[IW-1:0];
    tick();
    eoi_i = 1'b0;
    check(req, "err pulse", int'(err_o), bad);
    act_m[c][id] = 0;
    tick();
    check(req, "err one cycle", int'(err_o), 0);
    check_state(req);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin
      run_m[c] = 255;
      for (int i = 0; i < NI; i++) begin pend_m[c][i] = 0; act_m[c][i] = 0; prio_m[c][i] = 0; end
    end
    #20; rst_ni = 1'b1;
    tick();

    // R1: reset state, including the priority table
    check("R1", "err", int'(err_o), 0);
    check_state("R1");
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++) begin
        prio_rd_cpu_i = c[0]; prio_rd_id_i = i[IW-1:0]; #1;
        check("R1", $sformatf("prio reset c%0d id%0d", c, i), int'(prio_rd_data_o), 0);
      end

    // R10: fill per-CPU tables, then read all back
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++) do_prio(c, i, pattern(c, i));
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++) begin
        prio_rd_cpu_i = c[0]; prio_rd_id_i = i[IW-1:0]; #1;
        check("R10", $sformatf("prio c%0d id%0d", c, i), int'(prio_rd_data_o), pattern(c, i));
      end

    // R4: presented entry lags the pending change by one cycle
    raise_vld_i[0] = 1'b1; raise_id_i[0 +: IW] = 5'd30;
    tick();
    raise_vld_i = '0; pend_m[0][30] = 1;
    check("R4", "hp not yet valid", int'(hp_valid_o[0]), 0);
    tick();
    check("R4", "hp valid next cycle", int'(hp_valid_o[0]), 1);
    check("R4", "hp id", int'(hp_id_o[0 +: IW]), 30);
    do_ack(0, "R5");
    do_eoi(0, 30, "R7");

    // R2 R5 R8 R7: every ID alone on every CPU
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++) begin
        do_raise(c, i, "R2");
        do_ack(c, "R5");
        check("R8", "run equals acked prio", int'(run_prio_o[c*PW +: PW]), pattern(c, i));
        do_eoi(c, i, "R7");
      end

    // R3: ties between IDs 8 apart; lower ID wins; then a strictly smaller value
    do_raise(0, 27, "R3");
    do_raise(0, 19, "R3");
    check("R3", "tie picks 19", int'(hp_id_o[0 +: IW]), 19);
    do_raise(0, 3, "R3");
    check("R3", "tie picks 3", int'(hp_id_o[0 +: IW]), 3);
    do_raise(0, 9, "R3");
    check("R3", "smaller value 9", int'(hp_id_o[0 +: IW]), 9);
    // R8: nested actives give the minimum
    do_ack(0, "R8");
    do_ack(0, "R8");
    check("R8", "min of two actives", int'(run_prio_o[0 +: PW]), pattern(0, 9));
    do_eoi(0, 9, "R8");
    check("R8", "after retire", int'(run_prio_o[0 +: PW]), pattern(0, 3));
    do_ack(0, "R8");
    do_ack(0, "R8");
    do_eoi(0, 3, "R7");
    do_eoi(0, 19, "R7");
    do_eoi(0, 27, "R7");

    // R3: 0xFF priority never presented; R5: ack with nothing presented; R7: bad retire
    do_prio(1, 20, 255);
    do_raise(1, 20, "R3");
    check("R3", "ff not presented", int'(hp_valid_o[1]), 0);
    do_ack(1, "R5");
    check("R5", "no active after empty ack", int'(run_prio_o[PW +: PW]), 255);
    do_eoi(1, 20, "R7");

    // R2: both CPUs raise in the same cycle
    raise_vld_i = 2'b11; raise_id_i = {5'd12, 5'd12};
    tick();
    raise_vld_i = '0; pend_m[0][12] = 1; pend_m[1][12] = 1;
    tick();
    check_state("R2");
    do_ack(0, "R5");
    do_ack(1, "R5");
    do_eoi(0, 12, "R7");
    do_eoi(1, 12, "R7");

    // R6: raise collides with acknowledge on the same bit
    do_raise(0, 5, "R6");
    raise_vld_i[0] = 1'b1; raise_id_i[0 +: IW] = 5'd5; ack_i = 1'b1; ack_cpu_i = 1'b0;
    tick();
    raise_vld_i = '0; ack_i = 1'b0; act_m[0][5] = 1; pend_m[0][5] = 1;
    tick();
    check_state("R6");
    check("R6", "still presented", int'(hp_id_o[0 +: IW]), 5);
    do_ack(0, "R6");
    do_eoi(0, 5, "R7");

    // R9: disabled CPU holds its running priority
    cpu_en_i[1] = 1'b0;
    tick();
    do_raise(1, 4, "R9");
    do_ack(1, "R9");
    check("R9", "held while disabled", int'(run_prio_o[PW +: PW]), 255);
    cpu_en_i[1] = 1'b1;
    tick(); tick();
    check_state("R9");
    check("R9", "updates when enabled", int'(run_prio_o[PW +: PW]), pattern(1, 4));
    do_eoi(1, 4, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule